// File: doc/BRIEF.md
# Power-Domain Switch Controller

This block sits on a simple register port and switches a set of power domains on and off. Software first writes a mask of the domains to switch into the power-up mask register or the power-down mask register. It then writes a three-byte command to the command register: a parser-reset byte, then a two-byte unlock pair. The pair for power-up is not the same as the pair for power-down. Only a complete, correct command starts a switch.

Each domain has a fixed settle time that stands in for its power-switch latency. The status register shows which domains are powered. The lowest domains are always-on and a power-down never affects them. Completion, malformed commands, rejected commands and external power-handshake failures are recorded in two status registers, and one level interrupt output reports them. Both status registers are cleared by writing 1 to a bit.

Top module: `pwr_dom_ctrl`

## Requirements
- R1: After reset the power status (0x80) reads 0x03, because the NUM_AON=2 always-on domains are powered. Both domain masks and both status registers read 0. The interrupt mask (0x48) reads 0x1FF, which masks every source, and irq_o is low.
- R2: The power-up mask (0x0C) and the power-down mask (0x10) are writable, and only their low NUM_DOM bits are stored. A write to the power status register at 0x80 has no effect.
- R3: Writing 0xFF, 0x05 and 0x50 in turn to 0x44 powers up every domain whose power-up mask bit is 1 and which is off. Domain i reads as 1 exactly SETTLE_BASE + i*SETTLE_STEP cycles after the write of the last byte. Domains with a 0 mask bit keep their state.
- R4: Writing 0xFF, 0x0A and 0xA0 in turn to 0x44 powers down every powered domain whose power-down mask bit is 1, with the same per-domain timing as R3.
- R5: Domains below NUM_AON (bits 0 and 1) are never powered down, even when they are selected in the power-down mask.
- R6: Each of these returns the parser to idle, sets status bit 2 and starts no switch:
  - any byte other than 0xFF written while the parser is idle, including a pair sent without the reset byte;
  - a wrong second byte;
  - a wrong third byte.
- R7: A 0xFF byte at any point of a command restarts the parser and is not a failure.
- R8: A complete command that arrives while a switch is in progress is dropped, sets status bit 3 and changes no domain.
- R9: Status bit 0 (done) is set one cycle after the last selected domain's power bit changes. If no domain is selected, it is set one cycle after the command.
- R10: The event status register (0x88) records every event whatever the interrupt mask. The interrupt status register (0x8C) records only events whose mask bit (0x48) is 0, and irq_o is the OR of the interrupt status register. Writing 1 to a status bit clears it, and an event in the same cycle takes priority over the clear. Changing the mask does not move events that were recorded earlier.
- R11: A high pch_fail_i[k] in a cycle sets status bit 6+k.
- R12: Every switch sets done within SETTLE_BASE + (NUM_DOM-1)*SETTLE_STEP + 1 cycles of its command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| pch_fail_i | input | 3 | Power-handshake failure flags |
| dom_pwr_o | output | NUM_DOM | Power enable per domain |
| irq_o | output | 1 | Interrupt request, level |

## Verification
Reads are combinational, and register writes and status clears show up one cycle after the write edge. A domain's power bit changes SETTLE_BASE + i*SETTLE_STEP edges after the write of the final command byte, and done appears one edge after that. The bench counts falling edges from the return of the last write. For each timed result it reads once in the cycle before the result is due, expecting the old value, and once in the cycle it is due, expecting the new value. A malformed or rejected command is judged by its failure bit, which appears at the next edge. It is also judged by power status that stays unchanged for longer than the slowest settle time.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int IRQ_W  = 9;
  localparam int PCH_W  = 3;

  localparam logic [ADDR_W-1:0] A_ON_MASK  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_OFF_MASK = 8'h10;
  localparam logic [ADDR_W-1:0] A_CMD      = 8'h44;
  localparam logic [ADDR_W-1:0] A_IRQ_MASK = 8'h48;
  localparam logic [ADDR_W-1:0] A_PWR      = 8'h80;
  localparam logic [ADDR_W-1:0] A_EVT      = 8'h88;
  localparam logic [ADDR_W-1:0] A_IRQ      = 8'h8C;

  localparam logic [7:0] K_RESET = 8'hFF;
  localparam logic [7:0] K_ON_A  = 8'h05;
  localparam logic [7:0] K_ON_B  = 8'h50;
  localparam logic [7:0] K_OFF_A = 8'h0A;
  localparam logic [7:0] K_OFF_B = 8'hA0;

  localparam int B_DONE = 0;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_ARMED,
    PS_ON_HALF,
    PS_OFF_HALF
  } parse_st_e;
endpackage

// File: rtl/pdc_cmd_parser.sv
module pdc_cmd_parser
  import pdc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] byte_i,
  output logic       go_on_o,
  output logic       go_off_o,
  output logic       bad_o
);
  parse_st_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    go_on_o  = 1'b0;
    go_off_o = 1'b0;
    bad_o    = 1'b0;
    if (wr_i) begin
      if (byte_i == K_RESET) begin
        st_d = PS_ARMED;
      end else begin
        st_d = PS_IDLE;
        unique case (st_q)
          PS_ARMED: begin
            if (byte_i == K_ON_A)       st_d = PS_ON_HALF;
            else if (byte_i == K_OFF_A) st_d = PS_OFF_HALF;
            else                        bad_o = 1'b1;
          end
          PS_ON_HALF: begin
            if (byte_i == K_ON_B) go_on_o = 1'b1;
            else                  bad_o   = 1'b1;
          end
          PS_OFF_HALF: begin
            if (byte_i == K_OFF_B) go_off_o = 1'b1;
            else                   bad_o    = 1'b1;
          end
          default: bad_o = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= PS_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/pdc_domain_slot.sv
module pdc_domain_slot #(
  parameter int CNT_W     = 5,
  parameter int SETTLE    = 4,
  parameter bit ALWAYS_ON = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic turn_on_i,
  output logic pwr_o,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;
  logic             pwr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      pwr_q <= ALWAYS_ON;
    end else if (load_i) begin
      cnt_q <= CNT_W'(SETTLE);
      dir_q <= turn_on_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) pwr_q <= dir_q | ALWAYS_ON;
    end
  end

  assign pwr_o  = pwr_q;
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pdc_irq_ctrl.sv
module pdc_irq_ctrl #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         mask_wr_i,
  input  logic         evt_clr_i,
  input  logic         irq_clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] irq_stat_o,
  output logic         irq_o
);
  logic [W-1:0] mask_q, evt_q, irq_q;
  logic [W-1:0] evt_keep, irq_keep;

  assign evt_keep = evt_clr_i ? ~wdata_i : '1;
  assign irq_keep = irq_clr_i ? ~wdata_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      evt_q  <= '0;
      irq_q  <= '0;
    end else begin
      if (mask_wr_i) mask_q <= wdata_i;
      evt_q <= (evt_q & evt_keep) | evt_i;
      irq_q <= (irq_q & irq_keep) | (evt_i & ~mask_q);
    end
  end

  assign mask_o     = mask_q;
  assign evt_o      = evt_q;
  assign irq_stat_o = irq_q;
  assign irq_o      = |irq_q;
endmodule

// File: rtl/pwr_dom_ctrl.sv
module pwr_dom_ctrl
  import pdc_pkg::*;
#(
  parameter int NUM_DOM     = 7,
  parameter int NUM_AON     = 2,
  parameter int SETTLE_BASE = 4,
  parameter int SETTLE_STEP = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [PCH_W-1:0]   pch_fail_i,
  output logic [NUM_DOM-1:0] dom_pwr_o,
  output logic               irq_o
);
  localparam int MAX_SETTLE = SETTLE_BASE + (NUM_DOM - 1) * SETTLE_STEP;
  localparam int CNT_W      = $clog2(MAX_SETTLE + 1);
  localparam logic [NUM_DOM-1:0] AON_MASK = NUM_DOM'((1 << NUM_AON) - 1);

  logic [NUM_DOM-1:0] on_mask_q, off_mask_q;
  logic [NUM_DOM-1:0] sel, load, slot_busy, pwr;
  logic               go_on, go_off, seq_bad, accept, reject;
  logic               run_q, busy, done_evt;
  logic [IRQ_W-1:0]   evt, irq_mask, evt_stat, irq_stat;
  logic               wdata_unused;

  assign wdata_unused = ^reg_wdata_i[DATA_W-1:IRQ_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_mask_q  <= '0;
      off_mask_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_ON_MASK)  on_mask_q  <= reg_wdata_i[NUM_DOM-1:0];
      if (reg_addr_i == A_OFF_MASK) off_mask_q <= reg_wdata_i[NUM_DOM-1:0];
    end
  end

  pdc_cmd_parser u_parser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_we_i && reg_addr_i == A_CMD),
    .byte_i   (reg_wdata_i[7:0]),
    .go_on_o  (go_on),
    .go_off_o (go_off),
    .bad_o    (seq_bad)
  );

  assign accept = (go_on || go_off) && !run_q;
  assign reject = (go_on || go_off) && run_q;
  // only domains whose state actually changes are loaded
  assign sel    = go_on ? (on_mask_q & ~pwr) : (off_mask_q & ~AON_MASK & pwr);
  assign load   = accept ? sel : '0;

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
    pdc_domain_slot #(
      .CNT_W     (CNT_W),
      .SETTLE    (SETTLE_BASE + i * SETTLE_STEP),
      .ALWAYS_ON (i < NUM_AON)
    ) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load[i]),
      .turn_on_i (go_on),
      .pwr_o     (pwr[i]),
      .busy_o    (slot_busy[i])
    );
  end

  assign busy     = |slot_busy;
  assign done_evt = run_q && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= 1'b0;
    else if (accept)   run_q <= 1'b1;
    else if (done_evt) run_q <= 1'b0;
  end

  assign evt = {pch_fail_i, 2'b00, reject, seq_bad, 1'b0, done_evt};

  pdc_irq_ctrl #(.W(IRQ_W)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .mask_wr_i  (reg_we_i && reg_addr_i == A_IRQ_MASK),
    .evt_clr_i  (reg_we_i && reg_addr_i == A_EVT),
    .irq_clr_i  (reg_we_i && reg_addr_i == A_IRQ),
    .wdata_i    (reg_wdata_i[IRQ_W-1:0]),
    .mask_o     (irq_mask),
    .evt_o      (evt_stat),
    .irq_stat_o (irq_stat),
    .irq_o      (irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_ON_MASK:  reg_rdata_o = DATA_W'(on_mask_q);
      A_OFF_MASK: reg_rdata_o = DATA_W'(off_mask_q);
      A_IRQ_MASK: reg_rdata_o = DATA_W'(irq_mask);
      A_PWR:      reg_rdata_o = DATA_W'(pwr);
      A_EVT:      reg_rdata_o = DATA_W'(evt_stat);
      A_IRQ:      reg_rdata_o = DATA_W'(irq_stat);
      default:    reg_rdata_o = '0;
    endcase
  end

  assign dom_pwr_o = pwr;
endmodule

// File: rtl/pwr_dom_ctrl_chk.sv
module pwr_dom_ctrl_chk
  import pdc_pkg::*;
#(
  parameter int NUM_DOM     = 7,
  parameter int NUM_AON     = 2,
  parameter int SETTLE_BASE = 4,
  parameter int SETTLE_STEP = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cmd_wr_i,
  input logic [7:0]         cmd_byte_i,
  input logic [NUM_DOM-1:0] dom_pwr_o,
  input logic               irq_o,
  input logic               run_q,
  input logic               busy,
  input logic               done_masked_i
);
  localparam int MAX_SETTLE = SETTLE_BASE + (NUM_DOM - 1) * SETTLE_STEP;
  localparam int RW         = $clog2(MAX_SETTLE + 2) + 1;

  logic [RW-1:0] run_cnt;
  logic          odd_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    run_cnt <= '0;
    else if (run_q) run_cnt <= run_cnt + 1'b1;
    else            run_cnt <= '0;
  end

  assign odd_byte = cmd_wr_i && cmd_byte_i != K_RESET && cmd_byte_i != K_ON_A &&
                    cmd_byte_i != K_ON_B && cmd_byte_i != K_OFF_A && cmd_byte_i != K_OFF_B;

  p_aon_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dom_pwr_o[NUM_AON-1:0] == {NUM_AON{1'b1}});

  p_idle_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> $stable(dom_pwr_o));

  p_odd_byte_no_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odd_byte && !run_q |=> !run_q);

  p_switch_bound_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> run_cnt <= RW'(MAX_SETTLE));

  p_done_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !busy && !done_masked_i |=> irq_o);
endmodule

bind pwr_dom_ctrl pwr_dom_ctrl_chk #(
  .NUM_DOM     (NUM_DOM),
  .NUM_AON     (NUM_AON),
  .SETTLE_BASE (SETTLE_BASE),
  .SETTLE_STEP (SETTLE_STEP)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_wr_i      (reg_we_i && reg_addr_i == pdc_pkg::A_CMD),
  .cmd_byte_i    (reg_wdata_i[7:0]),
  .dom_pwr_o     (dom_pwr_o),
  .irq_o         (irq_o),
  .run_q         (run_q),
  .busy          (busy),
  .done_masked_i (irq_mask[pdc_pkg::B_DONE])
);

// File: tb/pwr_dom_ctrl_tb.sv
module pwr_dom_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_ONM = 8'h0C, A_OFFM = 8'h10, A_CMD = 8'h44, A_MSK = 8'h48,
                         A_PWR = 8'h80, A_EVT = 8'h88, A_IRQ = 8'h8C;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [2:0]  pch_fail_i = '0;
  logic [6:0]  dom_pwr_o;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done_f = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwr_dom_ctrl u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_addr_i = a;
    #1;
    chk(tag, reg_rdata_o, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic cmd3(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    wr(A_CMD, {24'h0, b0}); wr(A_CMD, {24'h0, b1}); wr(A_CMD, {24'h0, b2});
  endtask

  task automatic clr_all();
    wr(A_IRQ, 32'h1FF); wr(A_EVT, 32'h1FF);
  endtask

  task automatic t_reset();
    rdchk("R1 pwr", A_PWR, 32'h03);
    rdchk("R1 onmask", A_ONM, 32'h0);
    rdchk("R1 offmask", A_OFFM, 32'h0);
    rdchk("R1 irqmask", A_MSK, 32'h1FF);
    rdchk("R1 evt", A_EVT, 32'h0);
    rdchk("R1 irqstat", A_IRQ, 32'h0);
    chk("R1 irq_o", irq_o, 1'b0);
  endtask

  task automatic t_mask_rw();
    wr(A_ONM, 32'hFFFF_FFFF);
    rdchk("R2 onmask width", A_ONM, 32'h7F);
    wr(A_OFFM, 32'h55);
    rdchk("R2 offmask", A_OFFM, 32'h55);
    wr(A_PWR, 32'h7F);
    rdchk("R2 pwr read-only", A_PWR, 32'h03);
  endtask

  task automatic t_power_on();
    wr(A_MSK, 32'h0);
    clr_all();
    wr(A_ONM, 32'h14);
    cmd3(8'hFF, 8'h05, 8'h50);
    wait_n(9);  rdchk("R3 dom2 before", A_PWR, 32'h03);
    wait_n(1);  rdchk("R3 dom2 at 10", A_PWR, 32'h07);
    wait_n(5);  rdchk("R3 dom4 before", A_PWR, 32'h07);
    wait_n(1);  rdchk("R3 dom4 at 16", A_PWR, 32'h17);
    rdchk("R9 done not yet", A_IRQ, 32'h0);
    wait_n(1);  rdchk("R9 done +1", A_IRQ, 32'h1);
    chk("R10 irq_o on done", irq_o, 1'b1);
    chk("R3 dom_pwr_o", {25'h0, dom_pwr_o}, 32'h17);
    clr_all();
    chk("R10 irq_o cleared", irq_o, 1'b0);
  endtask

  task automatic t_power_off();
    wr(A_OFFM, 32'h13);
    cmd3(8'hFF, 8'h0A, 8'hA0);
    wait_n(15); rdchk("R4 dom4 before", A_PWR, 32'h17);
    wait_n(1);  rdchk("R4 R5 dom4 off, aon kept", A_PWR, 32'h07);
    wait_n(1);  rdchk("R9 done after off", A_EVT, 32'h1);
    clr_all();
  endtask

  task automatic t_empty();
    wr(A_ONM, 32'h04);
    cmd3(8'hFF, 8'h05, 8'h50);
    rdchk("R9 empty t0", A_EVT, 32'h0);
    wait_n(1);
    rdchk("R9 empty done +1", A_EVT, 32'h1);
    rdchk("R3 empty no change", A_PWR, 32'h07);
    clr_all();
  endtask

  task automatic t_bad_seq();
    wr(A_ONM, 32'h08);
    wr(A_CMD, 32'h05);
    rdchk("R6 byte in idle", A_EVT, 32'h4);
    wr(A_CMD, 32'h50);
    wait_n(25);
    rdchk("R6 pair without reset", A_PWR, 32'h07);
    clr_all();
    cmd3(8'hFF, 8'h05, 8'h33);
    rdchk("R6 bad third", A_EVT, 32'h4);
    clr_all();
    cmd3(8'hFF, 8'h0A, 8'h50);
    rdchk("R6 mixed pair", A_EVT, 32'h4);
    clr_all();
    cmd3(8'hFF, 8'h77, 8'h50);
    rdchk("R6 bad second", A_EVT, 32'h4);
    wait_n(25);
    rdchk("R6 no switch", A_PWR, 32'h07);
    rdchk("R6 mask kept", A_ONM, 32'h08);
    clr_all();
  endtask

  task automatic t_restart();
    wr(A_CMD, 32'hFF); wr(A_CMD, 32'h05);
    cmd3(8'hFF, 8'h05, 8'h50);
    wait_n(12); rdchk("R7 dom3 before", A_PWR, 32'h07);
    wait_n(1);  rdchk("R7 dom3 on after restart", A_PWR, 32'h0F);
    wait_n(1);  rdchk("R7 no failure, done", A_EVT, 32'h1);
    clr_all();
  endtask

  task automatic t_busy();
    wr(A_ONM, 32'h40);
    wr(A_OFFM, 32'h08);
    cmd3(8'hFF, 8'h05, 8'h50);
    cmd3(8'hFF, 8'h0A, 8'hA0);
    rdchk("R8 reject flag", A_EVT, 32'h8);
    wait_n(15); rdchk("R8 dom6 before", A_PWR, 32'h0F);
    wait_n(1);  rdchk("R3 dom6 at 22, R8 dom3 kept", A_PWR, 32'h4F);
    rdchk("R12 done not yet", A_EVT, 32'h8);
    wait_n(1);  rdchk("R12 done within bound", A_EVT, 32'h9);
    wait_n(25); rdchk("R8 no late effect", A_PWR, 32'h4F);
    clr_all();
  endtask

  task automatic t_masked();
    wr(A_MSK, 32'h1FF);
    wr(A_CMD, 32'h33);
    rdchk("R10 evt records masked", A_EVT, 32'h4);
    rdchk("R10 irqstat masked", A_IRQ, 32'h0);
    chk("R10 irq_o masked", irq_o, 1'b0);
    wr(A_MSK, 32'h0);
    chk("R10 unmask no retro", irq_o, 1'b0);
    clr_all();
  endtask

  task automatic t_pch();
    @(negedge clk_i); pch_fail_i = 3'b010;
    @(negedge clk_i); pch_fail_i = 3'b000;
    rdchk("R11 evt pch1", A_EVT, 32'h080);
    rdchk("R11 irqstat pch1", A_IRQ, 32'h080);
    chk("R11 irq_o", irq_o, 1'b1);
    wr(A_IRQ, 32'h080);
    chk("R10 w1c irq", irq_o, 1'b0);
    rdchk("R10 evt kept", A_EVT, 32'h080);
    wr(A_EVT, 32'h080);
    rdchk("R10 evt w1c", A_EVT, 32'h0);
  endtask

  task automatic finish_run();
    if (!done_f) begin
      done_f = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mask_rw();
    t_power_on();
    t_power_off();
    t_empty();
    t_bad_seq();
    t_restart();
    t_busy();
    t_masked();
    t_pch();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule